// File: doc/BRIEF.md
# Nested-Phase Hit Timestamp Encoder

This block builds a fine-grained arrival time for a detector hit by stacking several measurements, each finer than the last. A coarse counter runs freely on the base clock, and each tick stands for one reference period (25 ns at a 40 MHz reference). The sub-period measurements come from outside the block as digital snapshots, taken when the hit arrives:

- the index of the multiplied-clock phase, 8 phases of 3.125 ns each;
- a 32-cell delay-line thermometer that splits one phase into bins of about 98 ps;
- a 4-way interpolation thermometer that splits one bin into steps of about 24.4 ps.

The block does not model the analog circuits. It converts the two thermometer snapshots to binary and latches them with the counter and the phase index. It then sends out one packed timestamp word with a one-cycle valid strobe.

The host asserts `hit_i` for one base-clock cycle with the three snapshots stable. The timestamp appears on the next cycle. Every width is a parameter: counter width, multiplication factor, delay-line tap count and interpolation ways.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: While `rst_n` is low, `stamp_valid_o` is 0 and `stamp_o` is 0. At the first clock edge after release, the counter value is 0.
- R2: The coarse counter is 12 bits wide and advances by one on every clock edge out of reset. It wraps from 4095 to 0 with no other effect.
- R3: When `hit_i` is high at a clock edge, `stamp_valid_o` is high for exactly the following cycle and `stamp_o` carries the new word. Holding `hit_i` high for several cycles gives one stamp per cycle.
- R4: The word is 22 bits, with the most significant field first: coarse count in [21:10], phase index in [9:7], delay-line tap code in [6:2], interpolation code in [1:0].
- R5: The coarse field holds the counter value from before the increment at the capturing edge. Hits in back-to-back cycles therefore carry coarse values that differ by one.
- R6: The tap code is the lowest index i where `taps_i[i]` is 0. If every tap is 1, the code saturates at 31. If `taps_i[0]` is 0, the code is 0.
- R7: A bubble (a 0 below further 1s) resolves to the lowest 1-to-0 transition. For example, 32'h000000F7 gives 3 and 32'h00001EFF gives 8.
- R8: The interpolation code applies the same rule to the 4-bit `interp_i` (lowest index holding 0, or 3 if all bits are 1). For example, 4'b1101 gives 1.
- R9: The phase field equals `phase_i` as sampled at the capturing edge.
- R10: In a cycle after an edge with `hit_i` low, `stamp_valid_o` is 0 and `stamp_o` keeps its previous value, whatever the snapshot inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Hit strobe, one cycle per hit |
| phase_i | input | 3 | Multiplied-clock phase index at the hit |
| taps_i | input | 32 | Delay-line thermometer snapshot, tap 0 first |
| interp_i | input | 4 | Interpolation thermometer snapshot, bit 0 first |
| stamp_o | output | 22 | Packed timestamp word |
| stamp_valid_o | output | 1 | One-cycle strobe marking a new timestamp |

## Verification
The timestamp register is the only sequential stage after the inputs, so a wrong internal value shows on `stamp_o` in the cycle right after the hit that caught it.

A counter that skips, stalls or wraps early shows up as a gap between the coarse fields of back-to-back hits. Bubble patterns in the table expose an encoder that picks the highest transition or counts ones. A capture register that fails to hold shows up as a changed word on a cycle with no hit. Comparing against a bench counter run over a full 4096-cycle wrap exposes a counter of the wrong width.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;
   localparam int unsigned COARSE_W_DEF    = 12;
   localparam int unsigned PLL_MULT_DEF    = 8;
   localparam int unsigned DLL_TAPS_DEF    = 32;
   localparam int unsigned INTERP_WAYS_DEF = 4;

   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count_o
);
   if (W < 1) begin : g_bad_width
      $error("tdc_coarse_counter: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_o <= '0;
      else        count_o <= count_o + W'(1);
   end
endmodule

// File: rtl/tdc_therm_encoder.sv
module tdc_therm_encoder #(
   parameter  int unsigned N = 32,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] therm_i,
   output logic [W-1:0] code_o
);
   if (!tdc_stamp_pkg::is_pow2(N)) begin : g_bad_n
      $error("tdc_therm_encoder: N must be a power of two >= 2");
   end

   logic [N:0]   ones_below;
   logic [N-1:0] first_zero;

   assign ones_below[0] = 1'b1;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign ones_below[i+1] = ones_below[i] & therm_i[i];
      assign first_zero[i]   = ones_below[i] & ~therm_i[i];
   end

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (first_zero[i]) code_o = code_o | W'(i);
      end
      if (ones_below[N]) code_o = W'(N - 1);
   end
endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder
   import tdc_stamp_pkg::*;
#(
   parameter  int unsigned COARSE_W    = COARSE_W_DEF,
   parameter  int unsigned PLL_MULT    = PLL_MULT_DEF,
   parameter  int unsigned DLL_TAPS    = DLL_TAPS_DEF,
   parameter  int unsigned INTERP_WAYS = INTERP_WAYS_DEF,
   localparam int unsigned PH_W        = $clog2(PLL_MULT),
   localparam int unsigned TAP_W       = $clog2(DLL_TAPS),
   localparam int unsigned INT_W       = $clog2(INTERP_WAYS),
   localparam int unsigned STAMP_W     = COARSE_W + PH_W + TAP_W + INT_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hit_i,
   input  logic [PH_W-1:0]        phase_i,
   input  logic [DLL_TAPS-1:0]    taps_i,
   input  logic [INTERP_WAYS-1:0] interp_i,
   output logic [STAMP_W-1:0]     stamp_o,
   output logic                   stamp_valid_o
);
   if (!is_pow2(PLL_MULT)) begin : g_bad_mult
      $error("tdc_stamp_encoder: PLL_MULT must be a power of two >= 2");
   end

   logic [COARSE_W-1:0] coarse;
   logic [TAP_W-1:0]    tap_code;
   logic [INT_W-1:0]    int_code;

   tdc_coarse_counter #(.W(COARSE_W)) u_coarse (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (coarse)
   );

   tdc_therm_encoder #(.N(DLL_TAPS)) u_tap_enc (
      .therm_i (taps_i),
      .code_o  (tap_code)
   );

   tdc_therm_encoder #(.N(INTERP_WAYS)) u_int_enc (
      .therm_i (interp_i),
      .code_o  (int_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp_o       <= '0;
         stamp_valid_o <= 1'b0;
      end else begin
         stamp_valid_o <= hit_i;
         if (hit_i) stamp_o <= {coarse, phase_i, tap_code, int_code};
      end
   end
endmodule

// File: rtl/tdc_stamp_checker.sv
module tdc_stamp_checker #(
   parameter int unsigned COARSE_W    = 12,
   parameter int unsigned PLL_MULT    = 8,
   parameter int unsigned DLL_TAPS    = 32,
   parameter int unsigned INTERP_WAYS = 4,
   localparam int unsigned PH_W       = $clog2(PLL_MULT),
   localparam int unsigned TAP_W      = $clog2(DLL_TAPS),
   localparam int unsigned INT_W      = $clog2(INTERP_WAYS),
   localparam int unsigned STAMP_W    = COARSE_W + PH_W + TAP_W + INT_W,
   localparam int unsigned TAP_LO     = INT_W,
   localparam int unsigned PH_LO      = INT_W + TAP_W,
   localparam int unsigned CO_LO      = INT_W + TAP_W + PH_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   hit_i,
   input logic [PH_W-1:0]        phase_i,
   input logic [DLL_TAPS-1:0]    taps_i,
   input logic [INTERP_WAYS-1:0] interp_i,
   input logic [STAMP_W-1:0]     stamp_o,
   input logic                   stamp_valid_o
);
   AST_VALID_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(hit_i) |-> stamp_valid_o); // R3

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_valid_o |-> $past(hit_i)); // R10

   AST_HOLD_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_i |=> $stable(stamp_o)); // R10

   AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_valid_o && hit_i |=>
         stamp_o[STAMP_W-1:CO_LO] == COARSE_W'($past(stamp_o[STAMP_W-1:CO_LO]) + 1)); // R5

   AST_PHASE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> stamp_o[CO_LO-1:PH_LO] == $past(phase_i)); // R9

   AST_TAP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i && (&taps_i) |=> stamp_o[PH_LO-1:TAP_LO] == TAP_W'(DLL_TAPS - 1)); // R6

   AST_TAP_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i && !taps_i[0] |=> stamp_o[PH_LO-1:TAP_LO] == '0); // R6

   AST_INTERP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i && (&interp_i) |=> stamp_o[INT_W-1:0] == INT_W'(INTERP_WAYS - 1)); // R8
endmodule

bind tdc_stamp_encoder tdc_stamp_checker #(
   .COARSE_W(COARSE_W), .PLL_MULT(PLL_MULT),
   .DLL_TAPS(DLL_TAPS), .INTERP_WAYS(INTERP_WAYS)
) u_checker (
   .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .phase_i(phase_i),
   .taps_i(taps_i), .interp_i(interp_i),
   .stamp_o(stamp_o), .stamp_valid_o(stamp_valid_o)
);

// File: tb/tdc_stamp_encoder_test.sv
`timescale 1ns/1ps
module tdc_stamp_encoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hit_i = 1'b0;
   logic [2:0]  phase_i = '0;
   logic [31:0] taps_i = '0;
   logic [3:0]  interp_i = '0;
   logic [21:0] stamp_o;
   logic        stamp_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [11:0] mc = '0;

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mc <= '0;
      else        mc <= mc + 12'd1;
   end

   tdc_stamp_encoder uut (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .phase_i(phase_i),
      .taps_i(taps_i), .interp_i(interp_i),
      .stamp_o(stamp_o), .stamp_valid_o(stamp_valid_o)
   );

   typedef struct packed {
      logic [2:0]  ph;
      logic [31:0] taps;
      logic [3:0]  it;
      logic [4:0]  et;
      logic [1:0]  ei;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 32'h0000_0000, 4'b0000, 5'd0,  2'd0}, // R6 tap0 zero
      '{3'd1, 32'h0000_0001, 4'b0001, 5'd1,  2'd1}, // R6 R8
      '{3'd7, 32'h0000_FFFF, 4'b0011, 5'd16, 2'd2}, // R6 R8
      '{3'd5, 32'hFFFF_FFFF, 4'b1111, 5'd31, 2'd3}, // R6 R8 saturate
      '{3'd3, 32'h7FFF_FFFF, 4'b0111, 5'd31, 2'd3}, // R6 top tap zero
      '{3'd4, 32'h0000_00F7, 4'b1101, 5'd3,  2'd1}, // R7 bubbles
      '{3'd2, 32'h0000_1EFF, 4'b1010, 5'd8,  2'd0}, // R7 bubbles
      '{3'd6, 32'h0FFF_FFFF, 4'b0011, 5'd28, 2'd2}  // R6 R8
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // drive one hit at a negedge, check at the following negedge
   task automatic one_hit(input vec_t v, input string req);
      logic [21:0] exp;
      @(negedge clk);
      hit_i = 1'b1; phase_i = v.ph; taps_i = v.taps; interp_i = v.it;
      exp = {mc, v.ph, v.et, v.ei};
      @(negedge clk);
      hit_i = 1'b0;
      check(stamp_valid_o === 1'b1, {req, " valid"}, 32'(stamp_valid_o), 1);
      check(stamp_o === exp, req, 32'(stamp_o), 32'(exp));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [21:0] held;
      logic [11:0] c0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(stamp_valid_o === 1'b0, "R1 valid in reset", 32'(stamp_valid_o), 0);
      check(stamp_o === '0, "R1 stamp in reset", 32'(stamp_o), 0);
      // R1 first edge after release captures count 0
      rst_n = 1'b1;
      hit_i = 1'b1; phase_i = 3'd0; taps_i = 32'h1; interp_i = 4'b0001;
      @(negedge clk);
      hit_i = 1'b0;
      check(stamp_o[21:10] === 12'd0, "R1 first coarse", 32'(stamp_o[21:10]), 0);
      check(stamp_o === {12'd0, 3'd0, 5'd1, 2'd1}, "R4 layout", 32'(stamp_o), 32'({12'd0, 3'd0, 5'd1, 2'd1}));
      @(negedge clk);
      check(stamp_valid_o === 1'b0, "R3 single pulse", 32'(stamp_valid_o), 0);

      // table walk: R4 R6 R7 R8 R9
      foreach (VECS[i]) one_hit(VECS[i], "R6/R7/R8/R9 vector");

      // R10 no hit: inputs wiggle, word holds, valid low
      held = stamp_o;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         phase_i = 3'(k); taps_i = 32'h1234_5678 ^ 32'(k); interp_i = 4'(k);
      end
      @(negedge clk);
      check(stamp_valid_o === 1'b0, "R10 valid stays low", 32'(stamp_valid_o), 0);
      check(stamp_o === held, "R10 word held", 32'(stamp_o), 32'(held));

      // R3 R5 back-to-back hits give consecutive coarse values
      @(negedge clk);
      hit_i = 1'b1; taps_i = 32'h0000_000F; interp_i = 4'b0001; phase_i = 3'd2;
      c0 = mc;
      @(negedge clk);
      check(stamp_o[21:10] === c0, "R5 first of pair", 32'(stamp_o[21:10]), 32'(c0));
      @(negedge clk);
      hit_i = 1'b0;
      check(stamp_valid_o === 1'b1, "R3 held hit valid", 32'(stamp_valid_o), 1);
      check(stamp_o[21:10] === c0 + 12'd1, "R5 second of pair", 32'(stamp_o[21:10]), 32'(c0 + 12'd1));
      check(stamp_o[6:2] === 5'd4, "R6 tap of pair", 32'(stamp_o[6:2]), 4);

      // R2 wrap 4095 -> 0
      while (mc != 12'd4095) @(negedge clk);
      hit_i = 1'b1; phase_i = 3'd7; taps_i = 32'h0; interp_i = 4'b0;
      @(negedge clk);
      check(stamp_o[21:10] === 12'd4095, "R2 before wrap", 32'(stamp_o[21:10]), 4095);
      @(negedge clk);
      hit_i = 1'b0;
      check(stamp_o[21:10] === 12'd0, "R2 after wrap", 32'(stamp_o[21:10]), 0);
      check(stamp_o[9:7] === 3'd7, "R9 phase at wrap", 32'(stamp_o[9:7]), 7);

      // R1 reset in mid-run clears outputs
      rst_n = 1'b0;
      #1;
      check(stamp_valid_o === 1'b0 && stamp_o === '0, "R1 mid-run reset", 32'(stamp_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule